// File: doc/BRIEF.md
# Bank Auto-Precharge Timing Guard

This block sits beside the command scheduler of a DDR SDRAM controller and keeps the per-bank row timing that governs auto-precharge. It watches two kinds of event from the scheduler. The first is a row activate to a bank. The second is a read or write that carries an auto-precharge to a bank. From these it produces two flag vectors with one bit per bank. One bit says whether a command formed this cycle may carry an auto-precharge to that bank. The other says whether an activate to that bank may be issued this cycle.

The minimum active-to-precharge time (tRAS) and the precharge period (tRP) are parameters counted in clock cycles. A lock-out input selects one of two policies. When it is low, the guard itself withholds auto-precharge until tRAS has run since the activate. When it is high, the DRAM is trusted to defer the precharge internally, so the guard allows auto-precharge at once. It then starts the tRP window at the later of two points: the precharge issue, or the activate time plus tRAS.

An activate that arrives while its bank's flag is low is dropped and raises a sticky error output.

Top module: `bank_ap_guard`

## Requirements
- R1: After reset every bit of `act_ok` is 1, every bit of `ap_ok` is 0, `act_err` is 0, and the lock-out input is expected low.
- R2: An activate to bank b in a cycle where `act_ok[b]` is 1 opens the bank. From the next cycle `act_ok[b]` is 0 until the bank has been precharged and tRP has elapsed.
- R3: With `ras_lockout` at 0, `ap_ok[b]` of an open bank becomes 1 in the cycle exactly T_RAS cycles after the activate cycle, and not before.
- R4: With `ras_lockout` at 1, `ap_ok[b]` is 1 in every cycle the bank is open, starting the cycle after the activate.
- R5: An auto-precharge to an open bank closes it, so `ap_ok[b]` is 0 from the next cycle. When tRAS was already met at issue, `act_ok[b]` returns to 1 exactly T_RP cycles after the auto-precharge cycle.
- R6: An auto-precharge issued before tRAS is met (possible with lock-out at 1) delays the tRP window. `act_ok[b]` returns to 1 exactly T_RAS + T_RP cycles after the activate cycle.
- R7: An activate to a bank whose `act_ok` bit is 0 sets `act_err`, which stays 1 until reset. The bank's `act_ok` and `ap_ok` bits are left as they were.
- R8: An auto-precharge to a bank that is not open has no effect, so its `act_ok` stays 1.
- R9: Banks are independent. Events on one bank never change the flags of another.
- R10: An activate in the first cycle that `act_ok[b]` returns to 1 is accepted, with the same tRAS timing as from idle.
- R11: For no bank are `act_ok[b]` and `ap_ok[b]` both 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_lockout | input | 1 | 1: device enforces tRAS before auto-precharge; 0: guard enforces it |
| act_valid | input | 1 | Activate issued this cycle |
| act_bank | input | BANK_W | Bank of the activate |
| ap_valid | input | 1 | Read or write with auto-precharge issued this cycle |
| ap_bank | input | BANK_W | Bank of the auto-precharge |
| ap_ok | output | NUM_BANKS | Per bank: auto-precharge may be attached this cycle |
| act_ok | output | NUM_BANKS | Per bank: activate may be issued this cycle |
| act_err | output | 1 | Sticky: an activate arrived while its bank was blocked |

## Verification
A bank state machine stuck in the wrong state, or a down-counter loaded with an off-by-one value, shows at the flag ports within T_RAS + T_RP cycles of the next event on that bank. The flag then rises one cycle early or late against the time-stamp model in the bench, which is compared every cycle. A wrong choice of the tRP start under lock-out shows only when an auto-precharge comes before tRAS, so the bench forces that case directly and also lets random stimulus hit it. A lost or duplicated activate shows on the next cycle, either as `act_ok` staying high or as `act_err` rising.

// File: rtl/bank_ap_guard_pkg.sv
// Shared types for the bank auto-precharge timing guard.
package bank_ap_guard_pkg;

    // Life cycle of one bank as seen by the guard.
    typedef enum logic [1:0] {
        BK_IDLE     = 2'd0,  // closed, tRP met
        BK_OPEN     = 2'd1,  // row active
        BK_RAS_WAIT = 2'd2,  // auto-precharge issued, device still holding tRAS
        BK_PRECH    = 2'd3   // precharge running, counting tRP
    } bank_state_e;

endpackage

// File: rtl/bank_ap_guard_onehot.sv
// Turns a valid + bank index pair into a one-hot bank vector.
// Assumes the index is below NUM_BANKS whenever valid is high.
module bank_ap_guard_onehot #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic                 valid,
    input  logic [BANK_W-1:0]    idx,
    output logic [NUM_BANKS-1:0] hit
);

    // One comparator per bank.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cmp
        assign hit[g] = valid && (idx == BANK_W'(g));
    end

endmodule

// File: rtl/bank_ap_guard_downcnt.sv
// Saturating down-counter: loads a value and counts to zero, then holds.
// Assumes load_val fits in WIDTH bits.
module bank_ap_guard_downcnt #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             zero
);

    logic [WIDTH-1:0] cnt_q;

    // Load takes priority; otherwise step towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - WIDTH'(1);
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/bank_ap_guard_bank.sv
// Timing tracker for one bank. It holds the bank state, a tRAS counter started
// by each accepted activate, and a tRP counter started when the precharge
// becomes effective. Assumes T_RAS >= 1 and T_RP >= 1.
module bank_ap_guard_bank
    import bank_ap_guard_pkg::*;
#(
    parameter int T_RAS = 6,
    parameter int T_RP  = 3,
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_lockout,
    input  logic act_hit,
    input  logic ap_hit,
    output logic ap_ok,
    output logic act_ok,
    output logic act_bad
);

    localparam logic [CNT_W-1:0] RAS_LOAD = CNT_W'(T_RAS - 1);
    localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(T_RP - 1);

    bank_state_e state_q, state_d;
    logic        ras_zero, rp_zero;
    logic        act_take, rp_start;

    // An activate is taken only while the bank may be activated.
    assign act_take = act_hit && act_ok;
    assign act_bad  = act_hit && !act_ok;

    // The precharge becomes effective once tRAS is met after the auto-precharge.
    assign rp_start = ((state_q == BK_OPEN) && ap_hit && ras_zero) ||
                      ((state_q == BK_RAS_WAIT) && ras_zero);

    bank_ap_guard_downcnt #(.WIDTH(CNT_W)) u_ras_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (act_take),
        .load_val (RAS_LOAD),
        .zero     (ras_zero)
    );

    bank_ap_guard_downcnt #(.WIDTH(CNT_W)) u_rp_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rp_start),
        .load_val (RP_LOAD),
        .zero     (rp_zero)
    );

    // Next-state selection for the bank life cycle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_IDLE: begin
                if (act_take) state_d = BK_OPEN;
            end
            BK_OPEN: begin
                if (ap_hit) state_d = ras_zero ? BK_PRECH : BK_RAS_WAIT;
            end
            BK_RAS_WAIT: begin
                if (ras_zero) state_d = BK_PRECH;
            end
            BK_PRECH: begin
                if (act_take)     state_d = BK_OPEN;
                else if (rp_zero) state_d = BK_IDLE;
            end
            default: state_d = BK_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BK_IDLE;
        else        state_q <= state_d;
    end

    // Output flags: open bank gates auto-precharge, closed and rested bank gates activate.
    assign ap_ok  = (state_q == BK_OPEN) && (ras_lockout || ras_zero);
    assign act_ok = (state_q == BK_IDLE) || ((state_q == BK_PRECH) && rp_zero);

endmodule

// File: rtl/bank_ap_guard.sv
// Top of the bank auto-precharge timing guard. It decodes the scheduler's
// activate and auto-precharge events per bank, runs one tracker per bank,
// and keeps a sticky error for blocked activates.
// Assumes act_bank and ap_bank are below NUM_BANKS when their valid is high.
module bank_ap_guard #(
    parameter int NUM_BANKS = 4,
    parameter int T_RAS     = 6,
    parameter int T_RP      = 3,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ras_lockout,
    input  logic                 act_valid,
    input  logic [BANK_W-1:0]    act_bank,
    input  logic                 ap_valid,
    input  logic [BANK_W-1:0]    ap_bank,
    output logic [NUM_BANKS-1:0] ap_ok,
    output logic [NUM_BANKS-1:0] act_ok,
    output logic                 act_err
);

    localparam int MAX_T = (T_RAS > T_RP) ? T_RAS : T_RP;
    localparam int CNT_W = $clog2(MAX_T + 1);

    logic [NUM_BANKS-1:0] act_hit, ap_hit, act_bad;

    bank_ap_guard_onehot #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_act_dec (
        .valid (act_valid),
        .idx   (act_bank),
        .hit   (act_hit)
    );

    bank_ap_guard_onehot #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_ap_dec (
        .valid (ap_valid),
        .idx   (ap_bank),
        .hit   (ap_hit)
    );

    // One independent tracker per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_ap_guard_bank #(
            .T_RAS (T_RAS),
            .T_RP  (T_RP),
            .CNT_W (CNT_W)
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .ras_lockout (ras_lockout),
            .act_hit     (act_hit[b]),
            .ap_hit      (ap_hit[b]),
            .ap_ok       (ap_ok[b]),
            .act_ok      (act_ok[b]),
            .act_bad     (act_bad[b])
        );
    end

    // Sticky error: set by any blocked activate, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) act_err <= 1'b0;
        else        act_err <= act_err || (|act_bad);
    end

endmodule

// File: rtl/bank_ap_guard_chk.sv
// Port-level timing properties of the bank auto-precharge guard, bound to the top.
module bank_ap_guard_chk #(
    parameter int NUM_BANKS = 4,
    parameter int T_RAS     = 6,
    parameter int T_RP      = 3,
    parameter int BANK_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ras_lockout,
    input logic                 act_valid,
    input logic [BANK_W-1:0]    act_bank,
    input logic                 ap_valid,
    input logic [BANK_W-1:0]    ap_bank,
    input logic [NUM_BANKS-1:0] ap_ok,
    input logic [NUM_BANKS-1:0] act_ok,
    input logic                 act_err
);

    // R7: a blocked activate raises the error flag.
    p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid && !act_ok[act_bank] |=> act_err);

    // R7: the error flag is sticky.
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_err |=> act_err);

    // R2: an accepted activate blocks further activates next cycle.
    p_act_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid && act_ok[act_bank] |=> !act_ok[$past(act_bank)]);

    // R5: an auto-precharge to an allowed bank ends auto-precharge permission.
    p_ap_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ap_valid && ap_ok[ap_bank] |=> !ap_ok[$past(ap_bank)]);

    // R4: with lock-out set, an opened bank allows auto-precharge next cycle.
    p_lock_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid && act_ok[act_bank] && ras_lockout |=>
            (ap_ok[$past(act_bank)] || !ras_lockout));

    // R11: never both flags for one bank.
    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_ok & act_ok) == '0);

    // R3: without lock-out, no auto-precharge permission the cycle after an activate.
    if (T_RAS > 1) begin : g_ras_chk
        p_ras_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            act_valid && act_ok[act_bank] |=>
                (!ap_ok[$past(act_bank)] || ras_lockout));
    end

endmodule

bind bank_ap_guard bank_ap_guard_chk #(
    .NUM_BANKS (NUM_BANKS),
    .T_RAS     (T_RAS),
    .T_RP      (T_RP),
    .BANK_W    (BANK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ras_lockout (ras_lockout),
    .act_valid   (act_valid),
    .act_bank    (act_bank),
    .ap_valid    (ap_valid),
    .ap_bank     (ap_bank),
    .ap_ok       (ap_ok),
    .act_ok      (act_ok),
    .act_err     (act_err)
);

// File: tb/bank_ap_guard_bench.sv
`timescale 1ns/1ps
module bank_ap_guard_bench;

    localparam int NB    = 4;
    localparam int T_RAS = 6;
    localparam int T_RP  = 3;
    localparam int BW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_lockout = 1'b0;
    logic          act_valid = 1'b0;
    logic [BW-1:0] act_bank = '0;
    logic          ap_valid = 1'b0;
    logic [BW-1:0] ap_bank = '0;
    logic [NB-1:0] ap_ok, act_ok;
    logic          act_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Time-stamp model of the requirements.
    longint cyc = 0;
    bit     m_open  [NB];
    longint m_act   [NB];
    longint m_ready [NB];
    bit     m_err = 1'b0;

    always #2.5 clk = ~clk;

    bank_ap_guard #(.NUM_BANKS(NB), .T_RAS(T_RAS), .T_RP(T_RP), .BANK_W(BW)) u_bank_ap_guard (
        .clk (clk), .rst_n (rst_n), .ras_lockout (ras_lockout),
        .act_valid (act_valid), .act_bank (act_bank),
        .ap_valid (ap_valid), .ap_bank (ap_bank),
        .ap_ok (ap_ok), .act_ok (act_ok), .act_err (act_err)
    );

    function automatic bit exp_act_ok(int b);
        return !m_open[b] && (cyc >= m_ready[b]);
    endfunction

    function automatic bit exp_ap_ok(int b, bit lock);
        return m_open[b] && (lock || (cyc >= m_act[b] + T_RAS));
    endfunction

    function automatic longint later(longint a, longint b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    // One cycle: drive, compare flags against the model, then advance the model.
    task automatic step(bit av, int ab, bit pv, int pb, bit lock, string req);
        logic [NB-1:0] e_act, e_ap;
        bit take_act, take_ap;
        @(negedge clk);
        act_valid = av; act_bank = BW'(ab);
        ap_valid = pv; ap_bank = BW'(pb);
        ras_lockout = lock;
        #1;
        for (int b = 0; b < NB; b++) begin
            e_act[b] = exp_act_ok(b);
            e_ap[b]  = exp_ap_ok(b, lock);
        end
        check(act_ok == e_act, req, "act_ok", act_ok, e_act);
        check(ap_ok == e_ap, req, "ap_ok", ap_ok, e_ap);
        check(act_err == m_err, req, "act_err", act_err, m_err);
        check((ap_ok & act_ok) == '0, "R11", "flag overlap", ap_ok & act_ok, 0);
        take_act = av && exp_act_ok(ab);
        take_ap  = pv && m_open[pb];
        if (av && !take_act) m_err = 1'b1;
        if (take_ap) begin
            m_open[pb]  = 1'b0;
            m_ready[pb] = later(cyc, m_act[pb] + T_RAS) + T_RP;
        end
        if (take_act) begin
            m_open[ab] = 1'b1;
            m_act[ab]  = cyc;
        end
        cyc++;
    endtask

    task automatic idle(int n, bit lock, string req);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, lock, req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < NB; b++) begin
            m_open[b] = 0; m_act[b] = 0; m_ready[b] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: state right after reset.
        step(0, 0, 0, 0, 0, "R1");
        // R2 and R3: activate bank 0 with guard-enforced tRAS, precharge at first allowed cycle.
        step(1, 0, 0, 0, 0, "R2");
        idle(T_RAS - 1, 0, "R3");
        step(0, 0, 1, 0, 0, "R3");
        // R5 and R10: tRP window, then activate in its first allowed cycle.
        idle(T_RP - 1, 0, "R5");
        step(1, 0, 0, 0, 0, "R10");
        idle(T_RAS + 1, 0, "R10");
        step(0, 0, 1, 0, 0, "R5");
        idle(T_RP + 1, 0, "R5");
        // R4 and R6: lock-out set, early auto-precharge on bank 1 delays tRP.
        step(1, 1, 0, 0, 1, "R4");
        step(0, 0, 1, 1, 1, "R4");
        idle(T_RAS + T_RP + 1, 1, "R6");
        // R8: auto-precharge to an idle bank.
        step(0, 0, 1, 2, 0, "R8");
        step(0, 0, 0, 0, 0, "R8");
        // R9: random traffic across banks, activates steered to allowed banks.
        for (int i = 0; i < 3000; i++) begin
            int ab = $urandom_range(NB - 1);
            int pb = $urandom_range(NB - 1);
            bit av = ($urandom_range(99) < 45) && exp_act_ok(ab);
            bit pv = ($urandom_range(99) < 40);
            bit lk = (i / 250) % 2 == 1;
            step(av, ab, pv, pb, lk, "R9");
        end
        idle(T_RAS + T_RP + 2, 0, "R9");
        // R7: blocked activate on an open bank.
        step(1, 3, 0, 0, 0, "R7");
        step(1, 3, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, "R7");
        idle(3, 0, "R7");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5 * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule